// File: doc/BRIEF.md
# Multi-Page-Size Data Translation Buffer

This block is a fully associative translation buffer on the data side. It caches virtual-to-physical page mappings. Every entry holds its own page-size code, so mappings for 8KB, 64KB, 512KB and 4MB pages can sit side by side. A larger page compares fewer virtual page bits, and the virtual bits it does not compare pass straight through to the physical address.

A lookup presents a full 64-bit virtual address. One cycle later the block returns a hit flag, the physical address, an address-fault flag and a multi-hit flag. Only the low `VA_IMPL` virtual bits are translated, but every lookup also checks that bits 63 down to `VA_IMPL-1` are a proper sign extension. A separate fill port writes the next entry in round-robin order. A single invalidate input empties the whole buffer in one cycle.

Top module: `mpx_tlb`

## Requirements
- R1: After reset no entry is valid, `respValid` is 0, and every lookup misses until a fill is made.
- R2: `respValid` is 1 in exactly the cycle after a cycle with `lookupValid` high, and 0 otherwise.
- R3: A valid entry matches when its stored VPN equals lookup VA bits [VA_IMPL-1:13], ignoring the lowest 3*s bits of the VPN, where s is the entry's size code: 0 = 8KB, 1 = 64KB, 2 = 512KB, 3 = 4MB.
- R4: On a hit the physical address is formed as follows. Bits [12:0] and the 3*s VA bits above bit 12 come from the lookup VA. All other bits come from the entry's PFN.
- R5: If VA bits [63:VA_IMPL-1] are not all equal, `respAddrFault` is 1, and `respHit`, `respMultiHit` and `respPa` are 0.
- R6: On a miss, or when no response is valid, `respHit` is 0 and `respPa` is 0.
- R7: When more than one entry matches, the lowest-indexed entry supplies the address and `respMultiHit` is 1.
- R8: Fills go to slots in round-robin order. The pointer starts at slot 0 after reset or invalidate and wraps after slot ENTRIES-1, so the ENTRIES+1-th fill replaces the first.
- R9: `invalidateAll` clears every entry in one cycle, so a lookup in the next cycle misses.
- R10: A fill in the same cycle as `invalidateAll` is dropped.
- R11: A lookup in the same cycle as a fill sees the contents before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request |
| lookupVa | input | 64 | Virtual address to translate |
| fillEn | input | 1 | Write one entry |
| fillVpn | input | VA_IMPL-13 (30) | Virtual page number of the new entry |
| fillPfn | input | PA_BITS-13 (21) | Physical frame number of the new entry |
| fillSize | input | 2 | Page-size code of the new entry |
| invalidateAll | input | 1 | Clear every entry |
| respValid | output | 1 | Response present |
| respHit | output | 1 | Translation found |
| respPa | output | PA_BITS (34) | Translated physical address |
| respAddrFault | output | 1 | Non-canonical virtual address |
| respMultiHit | output | 1 | More than one entry matched |

## Verification
A corrupted valid bit or a stale tag shows up at the ports as a wrong hit or miss. This appears on the response one cycle after the lookup that touches the entry. A wrong size code shows up as a hit beyond the page boundary, or as frame bits in the part of the address that should pass through. A round-robin pointer that is off by one stays hidden until the buffer wraps, so the tests fill ENTRIES+1 times and then probe both the first and the second slot.

// File: rtl/mpx_tlb_pkg.sv
package mpx_tlb_pkg;
  localparam int BASE_SHIFT = 13;  // 8KB base page
  localparam int SIZE_STEP  = 3;   // each size code adds 3 pass-through bits

  typedef enum logic [1:0] {
    PG_8K   = 2'd0,
    PG_64K  = 2'd1,
    PG_512K = 2'd2,
    PG_4M   = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic wrEn;
    logic clrAll;
    logic capture;
  } tlb_strobe_t;
endpackage

// File: rtl/mpx_tlb_ctrl.sv
module mpx_tlb_ctrl
  import mpx_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDXW = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lookupValid,
  input  logic            fillEn,
  input  logic            invalidateAll,
  output tlb_strobe_t     strobe,
  output logic [IDXW-1:0] wrIdx
);
  logic [IDXW-1:0] ptrQ;

  always_comb begin
    strobe.clrAll  = invalidateAll;
    strobe.wrEn    = fillEn && !invalidateAll;
    strobe.capture = lookupValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN || invalidateAll) ptrQ <= '0;
    else if (fillEn) ptrQ <= (ptrQ == IDXW'(ENTRIES - 1)) ? '0 : ptrQ + 1'b1;
  end

  assign wrIdx = ptrQ;
endmodule

// File: rtl/mpx_tlb_datapath.sv
module mpx_tlb_datapath
  import mpx_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_IMPL = 43,
  parameter int PA_BITS = 34,
  localparam int IDXW = $clog2(ENTRIES),
  localparam int VPNW = VA_IMPL - BASE_SHIFT,
  localparam int PFNW = PA_BITS - BASE_SHIFT
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlb_strobe_t        strobe,
  input  logic [IDXW-1:0]    wrIdx,
  input  logic [VPNW-1:0]    fillVpn,
  input  logic [PFNW-1:0]    fillPfn,
  input  logic [1:0]         fillSize,
  input  logic [63:0]        lookupVa,
  output logic               respValid,
  output logic               respHit,
  output logic [PA_BITS-1:0] respPa,
  output logic               respAddrFault,
  output logic               respMultiHit
);
  logic [VPNW-1:0]    tagQ  [ENTRIES];
  logic [PFNW-1:0]    pfnQ  [ENTRIES];
  pg_size_e           sizeQ [ENTRIES];
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] matchVec;

  function automatic logic [VPNW-1:0] vpnMask(pg_size_e s);
    logic [VPNW-1:0] ones = '1;
    return ones << (SIZE_STEP * int'(s));
  endfunction

  function automatic logic [PFNW-1:0] pfnMask(pg_size_e s);
    logic [PFNW-1:0] ones = '1;
    return ones << (SIZE_STEP * int'(s));
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrAll) validQ <= '0;
    else if (strobe.wrEn) validQ[wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      tagQ[wrIdx]  <= fillVpn;
      pfnQ[wrIdx]  <= fillPfn;
      sizeQ[wrIdx] <= pg_size_e'(fillSize);
    end
  end

  logic [VPNW-1:0] vaVpn;
  assign vaVpn = lookupVa[VA_IMPL-1:BASE_SHIFT];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = validQ[g] && (((tagQ[g] ^ vaVpn) & vpnMask(sizeQ[g])) == '0);
  end

  logic            canonical;
  logic [IDXW-1:0] selIdx;
  logic            anyMatch, manyMatch;
  logic [PFNW-1:0] selMask, paHi;
  logic [PA_BITS-1:0] paNext;

  assign canonical = (&lookupVa[63:VA_IMPL-1]) || !(|lookupVa[63:VA_IMPL-1]);
  assign anyMatch  = |matchVec;
  assign manyMatch = (matchVec & (matchVec - 1'b1)) != '0;

  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDXW'(i);
    end
  end

  assign selMask = pfnMask(sizeQ[selIdx]);
  assign paHi    = (pfnQ[selIdx] & selMask) | (lookupVa[BASE_SHIFT +: PFNW] & ~selMask);
  assign paNext  = {paHi, lookupVa[BASE_SHIFT-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respHit       <= 1'b0;
      respPa        <= '0;
      respAddrFault <= 1'b0;
      respMultiHit  <= 1'b0;
    end else begin
      respValid     <= strobe.capture;
      respHit       <= strobe.capture && canonical && anyMatch;
      respAddrFault <= strobe.capture && !canonical;
      respMultiHit  <= strobe.capture && canonical && manyMatch;
      respPa        <= (strobe.capture && canonical && anyMatch) ? paNext : '0;
    end
  end
endmodule

// File: rtl/mpx_tlb.sv
module mpx_tlb
  import mpx_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_IMPL = 43,
  parameter int PA_BITS = 34
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lookupValid,
  input  logic [63:0]                   lookupVa,
  input  logic                          fillEn,
  input  logic [VA_IMPL-BASE_SHIFT-1:0] fillVpn,
  input  logic [PA_BITS-BASE_SHIFT-1:0] fillPfn,
  input  logic [1:0]                    fillSize,
  input  logic                          invalidateAll,
  output logic                          respValid,
  output logic                          respHit,
  output logic [PA_BITS-1:0]            respPa,
  output logic                          respAddrFault,
  output logic                          respMultiHit
);
  localparam int IDXW = $clog2(ENTRIES);

  tlb_strobe_t     strobe;
  logic [IDXW-1:0] wrIdx;

  mpx_tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .fillEn(fillEn),
    .invalidateAll(invalidateAll), .strobe(strobe), .wrIdx(wrIdx)
  );

  mpx_tlb_datapath #(.ENTRIES(ENTRIES), .VA_IMPL(VA_IMPL), .PA_BITS(PA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .fillSize(fillSize),
    .lookupVa(lookupVa), .respValid(respValid), .respHit(respHit),
    .respPa(respPa), .respAddrFault(respAddrFault), .respMultiHit(respMultiHit)
  );
endmodule

// File: rtl/mpx_tlb_chk.sv
module mpx_tlb_chk #(
  parameter int VA_IMPL = 43,
  parameter int PA_BITS = 34
) (
  input logic               clk,
  input logic               rstN,
  input logic               lookupValid,
  input logic [63:0]        lookupVa,
  input logic               fillEn,
  input logic               invalidateAll,
  input logic               respValid,
  input logic               respHit,
  input logic [PA_BITS-1:0] respPa,
  input logic               respAddrFault,
  input logic               respMultiHit
);
  // Set while no entry can be valid: after reset or invalidate, until a kept fill.
  logic emptyQ;
  always_ff @(posedge clk) begin
    if (!rstN || invalidateAll) emptyQ <= 1'b1;
    else if (fillEn) emptyQ <= 1'b0;
  end

  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);
  a_r5_noncanon_faults: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !((&lookupVa[63:VA_IMPL-1]) || !(|lookupVa[63:VA_IMPL-1])))
      |=> respAddrFault);
  a_r5_fault_blocks_hit: assert property (@(posedge clk) disable iff (!rstN)
    respAddrFault |-> (!respHit && !respMultiHit && respPa == '0));
  a_r4_offset_passes: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (!respHit || respPa[12:0] == $past(lookupVa[12:0])));
  a_r6_miss_zero_pa: assert property (@(posedge clk) disable iff (!rstN)
    !respHit |-> respPa == '0);
  a_r7_multi_implies_hit: assert property (@(posedge clk) disable iff (!rstN)
    respMultiHit |-> respHit);
  // R1, R9, R10, R11: a lookup while the buffer is empty cannot hit
  a_r9_empty_misses: assert property (@(posedge clk) disable iff (!rstN)
    (emptyQ && lookupValid) |=> !respHit);
endmodule

bind mpx_tlb mpx_tlb_chk #(.VA_IMPL(VA_IMPL), .PA_BITS(PA_BITS)) u_chk (.*);

// File: tb/mpx_tlb_bench.sv
module mpx_tlb_bench;
  localparam int ENTRIES = 32;
  localparam int VA_IMPL = 43;
  localparam int PA_BITS = 34;
  localparam int VPNW = VA_IMPL - 13;
  localparam int PFNW = PA_BITS - 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [63:0] lookupVa = '0;
  logic fillEn = 1'b0;
  logic [VPNW-1:0] fillVpn = '0;
  logic [PFNW-1:0] fillPfn = '0;
  logic [1:0] fillSize = '0;
  logic invalidateAll = 1'b0;
  logic respValid, respHit, respAddrFault, respMultiHit;
  logic [PA_BITS-1:0] respPa;

  int nVec = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  mpx_tlb #(.ENTRIES(ENTRIES), .VA_IMPL(VA_IMPL), .PA_BITS(PA_BITS)) u_mpx_tlb (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [PA_BITS-1:0] expPa(logic [63:0] va, logic [PFNW-1:0] pfn, int s);
    logic [PFNW-1:0] keep = ~((PFNW'(1) << (3 * s)) - 1'b1);
    return {(pfn & keep) | (va[PA_BITS-1:13] & ~keep), va[12:0]};
  endfunction

  task automatic doFill(logic [63:0] va, logic [PFNW-1:0] pfn, int s);
    @(negedge clk);
    fillEn = 1'b1; fillVpn = va[VA_IMPL-1:13]; fillPfn = pfn; fillSize = 2'(s);
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  task automatic doInval();
    @(negedge clk);
    invalidateAll = 1'b1;
    @(negedge clk);
    invalidateAll = 1'b0;
  endtask

  // Drives a lookup; results appear at the next negedge.
  task automatic doLookup(logic [63:0] va);
    @(negedge clk);
    lookupValid = 1'b1; lookupVa = va;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic testReset();
    check("R1 respValid after reset", respValid, 0);
    doLookup(64'h0000_0000_0000_2000);
    check("R2 respValid after lookup", respValid, 1);
    check("R1 miss after reset", respHit, 0);
    check("R6 pa zero on miss", respPa, 0);
    @(negedge clk);
    check("R2 respValid drops", respValid, 0);
  endtask

  task automatic testSizes();
    logic [63:0] base = 64'h0000_0345_6780_0000;
    logic [PFNW-1:0] pfn = 21'h1A5A5A;
    for (int s = 0; s < 4; s++) begin
      logic [63:0] inVa = base + (64'(1) << (13 + 3 * s)) - 64'h18;
      doInval();
      doFill(base, pfn, s);
      doLookup(inVa);
      check($sformatf("R3 hit inside size %0d", s), respHit, 1);
      check($sformatf("R4 pa size %0d", s), respPa, expPa(inVa, pfn, s));
      doLookup(base + (64'(1) << (13 + 3 * s)));
      check($sformatf("R3 miss past size %0d", s), respHit, 0);
    end
  endtask

  task automatic testCanonical();
    logic [63:0] negVa = 64'hFFFF_FC00_0000_2000;
    doInval();
    doFill(negVa, 21'h00F0F, 0);
    doLookup(negVa + 64'h10);
    check("R5 canonical negative hits", respHit, 1);
    check("R5 canonical no fault", respAddrFault, 0);
    check("R4 pa negative va", respPa, expPa(negVa + 64'h10, 21'h00F0F, 0));
    doLookup(negVa & 64'h7FFF_FFFF_FFFF_FFFF);
    check("R5 top bit flipped faults", respAddrFault, 1);
    check("R5 fault suppresses hit", respHit, 0);
    check("R5 fault pa zero", respPa, 0);
    doLookup(64'h0004_0000_0000_2000);
    check("R5 bit 50 set faults", respAddrFault, 1);
  endtask

  task automatic testMultiHit();
    logic [63:0] va = 64'h0000_0012_3440_0000;
    doInval();
    doFill(va, 21'h0ABC00, 3);
    doFill(va, 21'h011111, 0);
    doLookup(va + 64'h1234);
    check("R7 multi hit flag", respMultiHit, 1);
    check("R7 lowest index pa", respPa, expPa(va + 64'h1234, 21'h0ABC00, 3));
    doLookup(va + 64'h0010_0000);
    check("R7 single match no flag", respMultiHit, 0);
    check("R7 single match hits", respHit, 1);
  endtask

  task automatic testRoundRobin();
    doInval();
    for (int i = 0; i <= ENTRIES; i++) doFill(64'(i + 1) << 13, PFNW'(i + 7), 0);
    doLookup(64'(1) << 13);
    check("R8 first slot replaced", respHit, 0);
    doLookup(64'(2) << 13);
    check("R8 second slot kept", respHit, 1);
    check("R8 second slot pa", respPa, expPa(64'(2) << 13, PFNW'(8), 0));
    doLookup(64'(ENTRIES + 1) << 13);
    check("R8 wrapped fill present", respPa, expPa(64'(ENTRIES + 1) << 13, PFNW'(ENTRIES + 7), 0));
  endtask

  task automatic testInvalidate();
    logic [63:0] va = 64'h0000_0000_00AB_E000;
    doInval();
    doFill(va, 21'h00123, 0);
    doLookup(va);
    check("R9 hit before invalidate", respHit, 1);
    doInval();
    doLookup(va);
    check("R9 miss after invalidate", respHit, 0);
    @(negedge clk);
    invalidateAll = 1'b1; fillEn = 1'b1; fillVpn = va[VA_IMPL-1:13]; fillPfn = 21'h00456; fillSize = 2'd0;
    @(negedge clk);
    invalidateAll = 1'b0; fillEn = 1'b0;
    doLookup(va);
    check("R10 fill dropped under invalidate", respHit, 0);
  endtask

  task automatic testSameCycle();
    logic [63:0] va = 64'h0000_0000_0777_0000;
    doInval();
    @(negedge clk);
    fillEn = 1'b1; fillVpn = va[VA_IMPL-1:13]; fillPfn = 21'h00999; fillSize = 2'd0;
    lookupValid = 1'b1; lookupVa = va;
    @(negedge clk);
    fillEn = 1'b0; lookupValid = 1'b0;
    check("R11 lookup sees old contents", respHit, 0);
    doLookup(va);
    check("R11 fill visible next", respHit, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSizes();
    testCanonical();
    testMultiHit();
    testRoundRobin();
    testInvalidate();
    testSameCycle();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule